// File: doc/BRIEF.md
# Glitch-Free Clock Source Switcher

This block drives the core clock of a small processor from one of two oscillators: a fast primary and a slow secondary that is always running. A single select input chooses the source. When the select changes, the running source is gated off at the end of the fourth phase of the current instruction cycle. This freezes the core just before the next phase-1 edge. Control then passes to the target source. The target counts its own rising edges before it drives the core. When the target is a crystal-mode primary, it first waits out an oscillator start-up count and then does the sync count.

Each source has its own controller running in that source's clock domain. Each controller sees the select level and the other source's gate through two-flop synchronizers. A gate is only ever opened or closed on the falling edge of its own clock, and a controller only opens its gate after the other gate is seen closed. The two sources therefore never overlap, and no output pulse is shorter than the narrower half-period of the two inputs. If the select is reversed during a switch, the switch still completes. The reversed request is then served as a new switch.

Top module: `clk_src_switch`

## Requirements
- R1: With `rst_ni` low and right after its release, the primary drives `clk_sys_o` with no sync wait. `core_frz_o` is 0 and `src_sec_o` is 0. The first `clk_sys_o` rising edge after release is a phase-1 cycle (`ph1_o` = 1).
- R2: The two source gates are never open at the same time. Every high and every low interval of `clk_sys_o` is at least the shorter half-period of the two source clocks.
- R3: The core freezes only after a complete four-phase cycle, so each run segment of `clk_sys_o` holds a multiple of four rising edges. The first rising edge of each new segment is a phase-1 cycle (`ph1_o` = 1).
- R4: `sel_sec_i` = 1 selects the secondary and 0 selects the primary. A switch to the secondary keeps `core_frz_o` high for exactly 11 secondary rising edges: 2 synchronizer edges, 1 decision edge and 8 sync edges. This count does not depend on `pri_mode_i`.
- R5: `pri_mode_i` values 0, 1 and 2 are the low-power, standard and high-speed crystal modes. A switch to a primary in one of these modes keeps `core_frz_o` high for exactly 1035 primary rising edges: 3 lead-in edges, 1024 start-up edges and 8 sync edges.
- R6: `pri_mode_i` value 3 (external clock), value 4 (RC) and values 5 to 7 are non-crystal. A switch to a primary in one of these modes keeps `core_frz_o` high for exactly 11 primary rising edges.
- R7: `src_sec_o` is 1 while the secondary owns the core and 0 while the primary does. It never changes while `core_frz_o` is high, and it flips only after the new source drives the core.
- R8: If `sel_sec_i` is reversed while a switch is in progress, the pending switch still completes to its target. After that, the core returns to the newly selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri_i | input | 1 | Primary oscillator clock |
| clk_sec_i | input | 1 | Secondary (low-frequency, always running) oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_sec_i | input | 1 | Source select: 1 = secondary, 0 = primary |
| pri_mode_i | input | 3 | Primary mode: 0..2 crystal, 3 external clock, 4 RC, 5..7 non-crystal |
| clk_sys_o | output | 1 | Gated core clock |
| core_frz_o | output | 1 | High while both gates are closed (core frozen) |
| src_sec_o | output | 1 | Current owner of the core: 1 = secondary |
| ph1_o | output | 1 | High during a phase-1 cycle of the running source |

## Verification
Switches are driven in both directions under every primary mode. These include crystal modes, which must add the start-up count, non-crystal and unused mode codes, which must not, and a crystal mode on a switch to the secondary, where the mode must be ignored. The frozen interval is measured in rising edges of the target clock. An exact count therefore separates a missing or misordered synchronizer stage, a wrong sync count and a start-up wait applied in the wrong mode. A reversal of the select in the middle of a freeze tells a design that completes and then re-serves the request apart from one that drops it or deadlocks. Pulse widths, edge counts per segment and the phase at resume are tracked across the whole run.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int unsigned NSRC            = 2;
  localparam int unsigned SYNC_EDGES_DEF  = 8;
  localparam int unsigned OST_CYCLES_DEF  = 1024;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_OST  = 2'd1,
    LEG_SYNC = 2'd2,
    LEG_RUN  = 2'd3
  } leg_state_e;

  typedef enum logic [2:0] {
    PM_LP  = 3'd0,
    PM_XT  = 3'd1,
    PM_HS  = 3'd2,
    PM_EXT = 3'd3,
    PM_RC  = 3'd4
  } pri_mode_e;

  function automatic logic is_xtal(logic [2:0] m);
    return (m == PM_LP) || (m == PM_XT) || (m == PM_HS);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_leg.sv
module clksw_leg
  import clksw_pkg::*;
#(
  parameter bit          START_ON   = 1'b0,
  parameter int unsigned SYNC_EDGES = SYNC_EDGES_DEF,
  parameter int unsigned OST_CYCLES = OST_CYCLES_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       want_i,
  input  logic       other_en_i,
  input  logic       need_ost_i,
  output logic       en_o,
  output logic       own_o,
  output logic [1:0] phase_o
);

  localparam int unsigned CNT_MAX = (OST_CYCLES > SYNC_EDGES) ? OST_CYCLES : SYNC_EDGES;
  localparam int unsigned CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  logic want_s, oth_s;

  clksw_sync #(.STAGES(2), .RST_VAL(START_ON)) u_want_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_i),
    .q_o   (want_s)
  );

  clksw_sync #(.STAGES(2), .RST_VAL(!START_ON)) u_oth_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (other_en_i),
    .q_o   (oth_s)
  );

  leg_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    ph_q, ph_d;
  logic          seen_q, seen_d;
  logic          own_q, own_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    seen_d  = seen_q;
    own_d   = own_q;
    unique case (state_q)
      LEG_RUN: begin
        if (en_o) begin
          ph_d  = ph_q + 2'd1;
          own_d = 1'b1;
          // stop as Q4 begins; gate closes on the following falling edge
          if (ph_q == 2'd2 && !want_s) begin
            state_d = LEG_OFF;
            seen_d  = 1'b0;
          end
        end
      end
      LEG_OFF: begin
        if (oth_s) begin
          seen_d = 1'b1;
          own_d  = 1'b0;
        end else if (seen_q) begin
          // other side has run since this leg stopped: take over
          cnt_d   = '0;
          state_d = need_ost_i ? LEG_OST : LEG_SYNC;
        end
      end
      LEG_OST: begin
        if (oth_s) own_d = 1'b0;
        if (cnt_q == CW'(OST_CYCLES - 1)) begin
          cnt_d   = '0;
          state_d = LEG_SYNC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      LEG_SYNC: begin
        if (oth_s) own_d = 1'b0;
        if (cnt_q == CW'(SYNC_EDGES - 1)) begin
          state_d = LEG_RUN;
          ph_d    = 2'd3;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = LEG_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= START_ON ? LEG_RUN : LEG_OFF;
      cnt_q   <= '0;
      ph_q    <= 2'd3;
      seen_q  <= !START_ON;
      own_q   <= START_ON;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      seen_q  <= seen_d;
      own_q   <= own_d;
    end
  end

  // gate changes only while this clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= START_ON;
    else         en_o <= (state_q == LEG_RUN);
  end

  assign own_o   = own_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_EDGES = SYNC_EDGES_DEF,
  parameter int unsigned OST_CYCLES = OST_CYCLES_DEF
) (
  input  logic       clk_pri_i,
  input  logic       clk_sec_i,
  input  logic       rst_ni,
  input  logic       sel_sec_i,
  input  logic [2:0] pri_mode_i,
  output logic       clk_sys_o,
  output logic       core_frz_o,
  output logic       src_sec_o,
  output logic       ph1_o
);

  localparam bit [NSRC-1:0] START_VEC = NSRC'(1);  // primary owns the core out of reset

  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] want_v;
  logic [NSRC-1:0] ost_v;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] src_own;
  logic [NSRC-1:0] src_ph1;
  logic [1:0]      leg_ph [NSRC];

  assign src_clk = {clk_sec_i, clk_pri_i};
  assign want_v  = {sel_sec_i, ~sel_sec_i};
  assign ost_v   = {1'b0, is_xtal(pri_mode_i)};

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    logic en_w;
    clksw_leg #(
      .START_ON  (START_VEC[g]),
      .SYNC_EDGES(SYNC_EDGES),
      .OST_CYCLES(OST_CYCLES)
    ) u_leg (
      .clk_i     (src_clk[g]),
      .rst_ni    (rst_ni),
      .want_i    (want_v[g]),
      .other_en_i(src_en[NSRC-1-g]),
      .need_ost_i(ost_v[g]),
      .en_o      (en_w),
      .own_o     (src_own[g]),
      .phase_o   (leg_ph[g])
    );
    assign src_en[g]  = en_w;
    assign src_ph1[g] = en_w && (leg_ph[g] == 2'd0);
  end

  assign clk_sys_o  = |(src_clk & src_en);
  assign core_frz_o = ~|src_en;
  assign src_sec_o  = src_own[1] & ~src_own[0];
  assign ph1_o      = |src_ph1;

endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_EDGES = SYNC_EDGES_DEF,
  parameter int unsigned OST_CYCLES = OST_CYCLES_DEF
) (
  input logic       clk_pri_i,
  input logic       clk_sec_i,
  input logic       rst_ni,
  input logic [1:0] en_i,
  input logic [1:0] ph_pri_i,
  input logic [2:0] pri_mode_i,
  input logic       core_frz_o,
  input logic       src_sec_o
);

  localparam int unsigned LIMIT = SYNC_EDGES + OST_CYCLES + 4;
  localparam int unsigned FW    = $clog2(LIMIT + 1);

  logic [FW-1:0] frz_pri_cnt, frz_sec_cnt;

  always_ff @(posedge clk_pri_i or negedge rst_ni) begin
    if (!rst_ni)                        frz_pri_cnt <= '0;
    else if (!core_frz_o)               frz_pri_cnt <= '0;
    else if (frz_pri_cnt != FW'(LIMIT)) frz_pri_cnt <= frz_pri_cnt + 1'b1;
  end

  always_ff @(posedge clk_sec_i or negedge rst_ni) begin
    if (!rst_ni)                        frz_sec_cnt <= '0;
    else if (!core_frz_o)               frz_sec_cnt <= '0;
    else if (frz_sec_cnt != FW'(LIMIT)) frz_sec_cnt <= frz_sec_cnt + 1'b1;
  end

  assert_no_overlap_pri_R2: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    !(en_i[0] && en_i[1]));

  assert_no_overlap_sec_R2: assert property (@(posedge clk_sec_i) disable iff (!rst_ni)
    !(en_i[0] && en_i[1]));

  assert_freeze_at_q4_R3: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    $fell(en_i[0]) |-> ph_pri_i == 2'd3);

  assert_sec_sync_count_R4: assert property (@(posedge clk_sec_i) disable iff (!rst_ni)
    $rose(en_i[1]) |-> frz_sec_cnt >= FW'(SYNC_EDGES));

  assert_pri_startup_R5: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    ($rose(en_i[0]) && is_xtal(pri_mode_i)) |-> frz_pri_cnt >= FW'(SYNC_EDGES + OST_CYCLES));

  assert_pri_sync_count_R6: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    $rose(en_i[0]) |-> frz_pri_cnt >= FW'(SYNC_EDGES));

  assert_status_hold_R7: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    core_frz_o |-> $stable(src_sec_o));

endmodule

bind clk_src_switch clk_src_switch_chk #(
  .SYNC_EDGES(SYNC_EDGES),
  .OST_CYCLES(OST_CYCLES)
) u_chk (
  .clk_pri_i (clk_pri_i),
  .clk_sec_i (clk_sec_i),
  .rst_ni    (rst_ni),
  .en_i      (src_en),
  .ph_pri_i  (leg_ph[0]),
  .pri_mode_i(pri_mode_i),
  .core_frz_o(core_frz_o),
  .src_sec_o (src_sec_o)
);

// File: tb/clk_src_switch_tb.sv
`timescale 1ns/10ps
module clk_src_switch_tb;

  localparam real PRI_PERIOD = 10.0;
  localparam real SEC_PERIOD = 34.6;
  localparam real MIN_HALF   = 4.9;
  localparam int  POLL_LIM   = 40000;

  typedef struct packed {
    logic        sel;
    logic [2:0]  mode;
    int unsigned edges;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd3, 11},    // to sec, R4
    '{1'b0, 3'd2, 1035},  // HS crystal, R5
    '{1'b1, 3'd2, 11},    // to sec, mode ignored, R4
    '{1'b0, 3'd4, 11},    // RC, R6
    '{1'b1, 3'd0, 11},
    '{1'b0, 3'd0, 1035},  // LP crystal, R5
    '{1'b1, 3'd1, 11},
    '{1'b0, 3'd1, 1035},  // XT crystal, R5
    '{1'b1, 3'd3, 11},
    '{1'b0, 3'd3, 11},    // external clock, R6
    '{1'b1, 3'd7, 11},
    '{1'b0, 3'd7, 11}     // unused code, R6
  };

  logic       clk_pri, clk_sec, rst_n, sel_sec;
  logic [2:0] pri_mode;
  logic       clk_sys, core_frz, src_sec, ph1;

  clk_src_switch u_dut (
    .clk_pri_i (clk_pri),
    .clk_sec_i (clk_sec),
    .rst_ni    (rst_n),
    .sel_sec_i (sel_sec),
    .pri_mode_i(pri_mode),
    .clk_sys_o (clk_sys),
    .core_frz_o(core_frz),
    .src_sec_o (src_sec),
    .ph1_o     (ph1)
  );

  initial begin
    clk_pri = 1'b0;
    #0.05;
    forever #(PRI_PERIOD / 2.0) clk_pri = ~clk_pri;
  end

  initial begin
    clk_sec = 1'b0;
    forever #(SEC_PERIOD / 2.0) clk_sec = ~clk_sec;
  end

  int  n_chk = 0, n_fail = 0;
  int  fp = 0, fs = 0;
  int  seg_cnt = 0, bad_seg = 0, bad_ph = 0, narrow = 0, bad_src = 0;
  bit  saw_sec = 1'b0, mon_on = 1'b0;
  real t_rise = 0.0, t_fall = 0.0;

  always @(posedge clk_pri) if (core_frz) fp++;
  always @(posedge clk_sec) if (core_frz) fs++;

  always @(posedge clk_sys) begin
    if (mon_on && ($realtime - t_fall) < MIN_HALF) narrow++;
    t_rise = $realtime;
    seg_cnt++;
    if (mon_on && seg_cnt == 1) begin
      #1;
      if (!ph1) bad_ph++;
    end
  end

  always @(negedge clk_sys) begin
    if (mon_on && ($realtime - t_rise) < MIN_HALF) narrow++;
    t_fall = $realtime;
  end

  always @(posedge core_frz) begin
    if (mon_on && (seg_cnt % 4) != 0) bad_seg++;
    seg_cnt = 0;
  end

  always @(src_sec) begin
    if (mon_on && core_frz) bad_src++;
    if (src_sec) saw_sec = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_level(ref logic sig, input logic lvl);
    int n = 0;
    while (sig !== lvl && n < POLL_LIM) begin
      #1;
      n++;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    sel_sec  = 1'b0;
    pri_mode = 3'd2;
    #40.02;
    // R1: reset state
    check(src_sec == 1'b0, "R1 status in reset", src_sec, 0);
    check(core_frz == 1'b0, "R1 freeze in reset", core_frz, 0);
    check(clk_sys == clk_pri, "R1 primary drives in reset", clk_sys, clk_pri);
    #3;
    check(clk_sys == clk_pri, "R1 primary drives in reset", clk_sys, clk_pri);
    #59;
    seg_cnt = 0;
    rst_n   = 1'b1;
    mon_on  = 1'b1;
    @(posedge clk_sys);
    #1.02;
    check(ph1 == 1'b1, "R1 first edge is phase 1", ph1, 1);
    check(core_frz == 1'b0, "R1 no sync wait after reset", core_frz, 0);
    #200;

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      rq = VECS[i].sel ? "R4" : (VECS[i].edges == 1035 ? "R5" : "R6");
      pri_mode = VECS[i].mode;
      fp = 0;
      fs = 0;
      sel_sec = VECS[i].sel;
      wait_level(core_frz, 1'b1);
      check(src_sec == !VECS[i].sel, "R7 status held at freeze", src_sec, !VECS[i].sel);
      wait_level(core_frz, 1'b0);
      wait_level(src_sec, VECS[i].sel);
      #300;
      check(src_sec == VECS[i].sel && !core_frz, rq, src_sec, VECS[i].sel);
      if (VECS[i].sel) check(fs == int'(VECS[i].edges), "R4 frozen secondary edges", fs, VECS[i].edges);
      else             check(fp == int'(VECS[i].edges), {rq, " frozen primary edges"}, fp, VECS[i].edges);
    end

    // R8: reverse the select in the middle of a freeze (primary -> secondary -> primary)
    pri_mode = 3'd4;
    saw_sec  = 1'b0;
    sel_sec  = 1'b1;
    wait_level(core_frz, 1'b1);
    #30;
    sel_sec = 1'b0;
    wait_level(src_sec, 1'b1);
    check(saw_sec == 1'b1, "R8 pending switch completes", saw_sec, 1);
    wait_level(src_sec, 1'b0);
    wait_level(core_frz, 1'b0);
    #300;
    check(src_sec == 1'b0 && !core_frz, "R8 returns to primary", src_sec, 0);

    // R8: reverse while switching to a crystal primary (secondary -> primary -> secondary)
    sel_sec = 1'b1;
    wait_level(src_sec, 1'b1);
    wait_level(core_frz, 1'b0);
    #300;
    pri_mode = 3'd2;
    sel_sec  = 1'b0;
    wait_level(core_frz, 1'b1);
    #2000;
    sel_sec = 1'b1;
    wait_level(src_sec, 1'b0);
    check(src_sec == 1'b0, "R8 crystal switch completes", src_sec, 0);
    wait_level(src_sec, 1'b1);
    wait_level(core_frz, 1'b0);
    #300;
    check(src_sec == 1'b1 && !core_frz, "R8 returns to secondary", src_sec, 1);

    check(narrow == 0, "R2 narrow pulses", narrow, 0);
    check(bad_seg == 0, "R3 segments not whole cycles", bad_seg, 0);
    check(bad_ph == 0, "R3 resume not at phase 1", bad_ph, 0);
    check(bad_src == 0, "R7 status moved while frozen", bad_src, 0);
    finish_run();
  end

endmodule